// File: doc/BRIEF.md
# Parallel Programming Command Sequencer

This block is the command front end of a parallel programming port for on-chip memory. A host presents a 4-bit mode field and a 16-bit data word and hands each word over with a request/acknowledge pair. The first word of a command is a command code. A write command is followed by a two-part address, low half first and upper part second. It then takes any number of data words. Each data word goes out on a one-cycle memory write strobe and the word address advances by one. A fresh address pair may be given in the middle of a burst to move the pointer.

A lock command, confirmed by a zero data word, sets a sticky lock. From then on every handshake is refused and acknowledge never rises. Only a long, unbroken assertion of the erase input clears the lock. When the erase input has been held for more than a parameterised number of cycles, the block pulses a memory-wipe strobe for one cycle. It also clears the lock and returns the sequencer to idle. A shorter pulse is forgotten.

Top module: `pport_cmd_seq`

## Requirements
- R1: Mode codes are command-entry 4'h1, address-low 4'h2, address-high 4'h3 and data 4'h4. A handshake with any other mode is acknowledged and has no other effect.
- R2: A word is taken on a rising edge of `reqIn`. `ackOut` goes high on the clock edge that samples the rise, unless the port is locked. It stays high until the edge that samples `reqIn` low. After reset `ackOut`, `memWrEn`, `memWipe`, `lockOut` and `errOut` are low.
- R3: After the write command (code 16'h00A1), an address-low word gives address bits [15:0]. A following address-high word gives the upper ADDR_W-16 bits from its low data bits. The address is usable only once the high word has followed a low word.
- R4: In a write burst with a usable address, each data handshake gives one `memWrEn` pulse on the edge that samples the request. The pulse carries the current address and the word, and the address then increments by one.
- R5: A new low/high address pair inside a burst moves the pointer, and later data words continue from the new address.
- R6: The lock command (code 16'h00C5) followed by a data word of 0 sets `lockOut`. A non-zero data word leaves the lock clear. While locked, no handshake is acknowledged and no write occurs.
- R7: Holding `eraseIn` high for ERASE_CYCLES+1 consecutive sampled cycles gives a one-cycle `memWipe` pulse. The same edge clears the lock and returns the sequencer to idle with no usable address. It fires once per assertion.
- R8: A release of `eraseIn` before that count resets the duration count and has no effect.
- R9: A data handshake in a write burst without a usable address sets `errOut` and writes nothing. The next command-entry handshake clears `errOut`.
- R10: A command-entry handshake ends any burst, so a new address is needed. After an unknown command code, data words are ignored without error.
- R11: The word address wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| reqIn | input | 1 | host request |
| modeIn | input | 4 | mode of the presented word |
| dataIn | input | 16 | presented data word |
| eraseIn | input | 1 | erase request input |
| ackOut | output | 1 | handshake acknowledge |
| memWrEn | output | 1 | one-cycle memory write strobe |
| memAddr | output | ADDR_W | word address of the write |
| memData | output | 16 | word to write |
| memWipe | output | 1 | one-cycle whole-memory erase strobe |
| lockOut | output | 1 | lock state |
| errOut | output | 1 | data-before-address error flag |

## Verification
A wrong sequencer state shows on the edge that samples the next handshake. A lost address phase raises `errOut` or drops a write strobe. A stale pointer puts the wrong value on `memAddr` at the very next `memWrEn` pulse. A lock or erase-count fault shows either as a missing acknowledge one edge after a request rise, or as a wipe strobe that arrives one cycle too early or too late. The bench's per-clock model compares every one of these outputs on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam logic [3:0] MODE_CMD   = 4'h1;
  localparam logic [3:0] MODE_ADDRL = 4'h2;
  localparam logic [3:0] MODE_ADDRH = 4'h3;
  localparam logic [3:0] MODE_DATA  = 4'h4;

  localparam logic [15:0] CODE_WRITE = 16'h00A1;
  localparam logic [15:0] CODE_LOCK  = 16'h00C5;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_LOCK  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic writeWord;
  } dpStrobe_t;
endpackage

// File: rtl/pport_erase_timer.sv
module pport_erase_timer #(
  parameter int unsigned ERASE_CYCLES = 11_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic eraseIn,
  output logic fire,
  output logic wipe
);
  localparam int unsigned CNT_W = $clog2(ERASE_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERASE_CYCLES);

  logic [CNT_W-1:0] holdCnt;

  assign fire = eraseIn && (holdCnt == LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      wipe    <= 1'b0;
    end else begin
      wipe <= fire;
      if (!eraseIn)
        holdCnt <= '0;
      else if (holdCnt <= LIMIT)
        holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic [3:0]  modeIn,
  input  logic [15:0] dataIn,
  input  logic        eraseFire,
  output logic        ackOut,
  output logic        lockOut,
  output logic        errOut,
  output dpStrobe_t   strobe
);
  seqState_t state;
  logic reqPrev;
  logic lowSeen;
  logic addrReady;
  logic reqRise;
  logic accept;

  assign reqRise = reqIn && !reqPrev;
  assign accept  = reqRise && !lockOut && !eraseFire;

  always_comb begin
    strobe = '0;
    if (accept && state == SEQ_WRITE) begin
      strobe.loadLow   = (modeIn == MODE_ADDRL);
      strobe.loadHigh  = (modeIn == MODE_ADDRH) && lowSeen;
      strobe.writeWord = (modeIn == MODE_DATA) && addrReady;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev   <= 1'b0;
      ackOut    <= 1'b0;
      lockOut   <= 1'b0;
      errOut    <= 1'b0;
      lowSeen   <= 1'b0;
      addrReady <= 1'b0;
      state     <= SEQ_IDLE;
    end else begin
      reqPrev <= reqIn;
      if (accept)
        ackOut <= 1'b1;
      else if (!reqIn)
        ackOut <= 1'b0;

      if (eraseFire) begin
        lockOut   <= 1'b0;
        errOut    <= 1'b0;
        lowSeen   <= 1'b0;
        addrReady <= 1'b0;
        state     <= SEQ_IDLE;
      end else if (accept) begin
        if (modeIn == MODE_CMD) begin
          errOut    <= 1'b0;
          lowSeen   <= 1'b0;
          addrReady <= 1'b0;
          if (dataIn == CODE_WRITE)
            state <= SEQ_WRITE;
          else if (dataIn == CODE_LOCK)
            state <= SEQ_LOCK;
          else
            state <= SEQ_IDLE;
        end else begin
          case (state)
            SEQ_WRITE: begin
              if (strobe.loadLow) begin
                lowSeen   <= 1'b1;
                addrReady <= 1'b0;
              end
              if (strobe.loadHigh) begin
                lowSeen   <= 1'b0;
                addrReady <= 1'b1;
              end
              if (modeIn == MODE_DATA && !addrReady)
                errOut <= 1'b1;
            end
            SEQ_LOCK: begin
              if (modeIn == MODE_DATA) begin
                state <= SEQ_IDLE;
                if (dataIn == 16'h0000)
                  lockOut <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pport_dpath.sv
module pport_dpath
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [15:0]       dataIn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData
);
  localparam int unsigned HI_W = ADDR_W - 16;

  logic [15:0]       lowReg;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowReg  <= '0;
      curAddr <= '0;
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strobe.writeWord;
      if (strobe.loadLow)
        lowReg <= dataIn;
      if (strobe.loadHigh)
        curAddr <= {dataIn[HI_W-1:0], lowReg};
      else if (strobe.writeWord)
        curAddr <= curAddr + 1'b1;
      if (strobe.writeWord) begin
        memAddr <= curAddr;
        memData <= dataIn;
      end
    end
  end
endmodule

// File: rtl/pport_cmd_seq.sv
module pport_cmd_seq
  import pport_pkg::*;
#(
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned ERASE_CYCLES = 11_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  input  logic [3:0]        modeIn,
  input  logic [15:0]       dataIn,
  input  logic              eraseIn,
  output logic              ackOut,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic              memWipe,
  output logic              lockOut,
  output logic              errOut
);
  dpStrobe_t strobe;
  logic eraseFire;

  pport_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rstN(rstN), .eraseIn(eraseIn),
    .fire(eraseFire), .wipe(memWipe)
  );

  pport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .modeIn(modeIn),
    .dataIn(dataIn), .eraseFire(eraseFire), .ackOut(ackOut),
    .lockOut(lockOut), .errOut(errOut), .strobe(strobe)
  );

  pport_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/pport_cmd_seq_chk.sv
module pport_cmd_seq_chk (
  input logic clk,
  input logic rstN,
  input logic ackOut,
  input logic memWrEn,
  input logic memWipe,
  input logic lockOut,
  input logic errOut
);
  // R4: one write per handshake, never back to back
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R2: every write belongs to an acknowledged handshake
  assert_write_acked_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ackOut);

  // R6: a locked port never writes
  assert_no_write_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |-> !memWrEn);

  // R6: a locked port never raises acknowledge
  assert_no_ack_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockOut) |-> !$rose(ackOut));

  // R7: the wipe strobe lasts one cycle and leaves the lock clear
  assert_wipe_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWipe |=> !memWipe);
  assert_wipe_unlocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWipe |-> !lockOut);

  // R9: the handshake that raises the error writes nothing
  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOut) |-> !memWrEn);
endmodule

bind pport_cmd_seq pport_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .ackOut(ackOut), .memWrEn(memWrEn),
  .memWipe(memWipe), .lockOut(lockOut), .errOut(errOut)
);

// File: tb/sim_pport_cmd_seq.sv
module sim_pport_cmd_seq;
  localparam int unsigned AW  = 24;
  localparam int unsigned LIM = 20;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0;
  logic [3:0] modeIn = 4'h0;
  logic [15:0] dataIn = 16'h0;
  logic eraseIn = 1'b0;
  logic ackOut, memWrEn, memWipe, lockOut, errOut;
  logic [AW-1:0] memAddr;
  logic [15:0] memData;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int wipes = 0;
  int writes = 0;
  logic [15:0] mem [int];

  always #10 clk = ~clk;

  pport_cmd_seq #(.ADDR_W(AW), .ERASE_CYCLES(LIM)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .modeIn(modeIn), .dataIn(dataIn),
    .eraseIn(eraseIn), .ackOut(ackOut), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .memWipe(memWipe), .lockOut(lockOut), .errOut(errOut)
  );

  // behavioural reference model
  bit mPrev, mAck, mLock, mErr, mLowGot, mValid, eWr, eWipe;
  int mState;  // 0 idle, 1 writing, 2 awaiting lock confirm
  int mLow, mAddr, eAddr, eData, eCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 0; mAck = 0; mLock = 0; mErr = 0; mLowGot = 0; mValid = 0;
      eWr = 0; eWipe = 0; mState = 0; mLow = 0; mAddr = 0; eCnt = 0;
    end else begin
      bit rise, fire, take;
      rise = reqIn && !mPrev;
      fire = eraseIn && (eCnt == LIM);
      take = rise && !mLock && !fire;
      eWr = 0;
      eWipe = fire;
      if (take) mAck = 1; else if (!reqIn) mAck = 0;
      if (!eraseIn) eCnt = 0; else if (eCnt <= LIM) eCnt++;
      if (fire) begin
        mLock = 0; mErr = 0; mLowGot = 0; mValid = 0; mState = 0;
      end else if (take) begin
        if (modeIn == 4'h1) begin
          mErr = 0; mLowGot = 0; mValid = 0;
          mState = (dataIn == 16'h00A1) ? 1 : (dataIn == 16'h00C5) ? 2 : 0;
        end else if (mState == 1) begin
          if (modeIn == 4'h2) begin mLow = dataIn; mLowGot = 1; mValid = 0; end
          else if (modeIn == 4'h3 && mLowGot) begin
            mAddr = ((int'(dataIn) << 16) | mLow) & AMASK;
            mLowGot = 0; mValid = 1;
          end else if (modeIn == 4'h4) begin
            if (mValid) begin
              eWr = 1; eAddr = mAddr; eData = dataIn;
              mAddr = (mAddr + 1) & AMASK;
            end else mErr = 1;
          end
        end else if (mState == 2 && modeIn == 4'h4) begin
          mState = 0;
          if (dataIn == 16'h0) mLock = 1;
        end
      end
      mPrev = reqIn;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison and write log
  always @(negedge clk) begin
    if (rstN) begin
      check(ackOut == mAck, "R2 ack", ackOut, mAck);
      check(memWrEn == eWr, "R4 write strobe", memWrEn, eWr);
      if (eWr) begin
        check(int'(memAddr) == eAddr, "R4 write address", memAddr, eAddr);
        check(int'(memData) == eData, "R4 write data", memData, eData);
      end
      check(lockOut == mLock, "R6 lock", lockOut, mLock);
      check(errOut == mErr, "R9 error", errOut, mErr);
      check(memWipe == eWipe, "R7 wipe", memWipe, eWipe);
      if (memWrEn) begin mem[int'(memAddr)] = memData; writes++; end
      if (memWipe) begin mem.delete(); wipes++; end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [3:0] m, input logic [15:0] d);
    @(negedge clk);
    modeIn = m; dataIn = d; reqIn = 1'b1;
    tick(2);
    reqIn = 1'b0;
    tick(2);
  endtask

  function automatic int rd(input int a);
    return mem.exists(a) ? int'(mem[a]) : -1;
  endfunction

  task automatic hold_erase(input int n);
    @(negedge clk);
    eraseIn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    eraseIn = 1'b0;
    tick(3);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int w0;
    tick(3);
    check(!ackOut && !memWrEn && !memWipe && !lockOut && !errOut, "R2 reset state",
          {ackOut, memWrEn, memWipe, lockOut, errOut}, 0);
    rstN = 1'b1;
    tick(2);

    // R3 R4: address assembly and incrementing burst
    send(4'h1, 16'h00A1); send(4'h2, 16'h0010); send(4'h3, 16'h0012);
    send(4'h4, 16'hAAAA); send(4'h4, 16'hBBBB); send(4'h4, 16'hCCCC);
    check(rd(32'h120010) == 16'hAAAA, "R3 first word address", rd(32'h120010), 16'hAAAA);
    check(rd(32'h120012) == 16'hCCCC, "R4 third word incremented", rd(32'h120012), 16'hCCCC);

    // R5: re-address mid burst
    send(4'h2, 16'h0040); send(4'h3, 16'h0000);
    send(4'h4, 16'h1111); send(4'h4, 16'h2222);
    check(rd(32'h41) == 16'h2222, "R5 continues from new address", rd(32'h41), 16'h2222);
    check(rd(32'h120013) == -1, "R5 old pointer unused", rd(32'h120013), -1);

    // R1: unknown mode ignored but acknowledged
    w0 = writes;
    @(negedge clk); modeIn = 4'hF; dataIn = 16'h5555; reqIn = 1'b1; tick(2);
    check(ackOut == 1'b1, "R1 unknown mode acked", ackOut, 1);
    reqIn = 1'b0; tick(2);
    send(4'h4, 16'h3333);
    check(rd(32'h42) == 16'h3333, "R1 unknown mode left burst intact", rd(32'h42), 16'h3333);

    // R3 R9: data after low half only
    send(4'h2, 16'h0100);
    w0 = writes;
    send(4'h4, 16'hDEAD);
    check(errOut == 1'b1, "R3 R9 data without full address", errOut, 1);
    check(writes == w0, "R9 dropped word", writes, w0);
    send(4'h1, 16'h00A1);
    check(errOut == 1'b0, "R9 command clears error", errOut, 0);

    // R11: wrap
    send(4'h2, 16'hFFFF); send(4'h3, 16'h00FF);
    send(4'h4, 16'h7777); send(4'h4, 16'h8888);
    check(rd(AMASK) == 16'h7777, "R11 top address", rd(AMASK), 16'h7777);
    check(rd(0) == 16'h8888, "R11 wraps to zero", rd(0), 16'h8888);

    // R10: command entry ends burst; unknown code ignores data
    send(4'h1, 16'h00A1); send(4'h4, 16'h4444);
    check(errOut == 1'b1, "R10 new command needs address", errOut, 1);
    send(4'h1, 16'h0077);
    w0 = writes;
    send(4'h2, 16'h0005); send(4'h3, 16'h0000); send(4'h4, 16'h4545);
    check(errOut == 1'b0 && writes == w0, "R10 unknown code ignores words", writes, w0);

    // R6: lock confirm
    send(4'h1, 16'h00C5); send(4'h4, 16'h0001);
    check(lockOut == 1'b0, "R6 nonzero confirm leaves unlocked", lockOut, 0);
    send(4'h1, 16'h00C5); send(4'h4, 16'h0000);
    check(lockOut == 1'b1, "R6 lock set", lockOut, 1);
    w0 = writes;
    @(negedge clk); modeIn = 4'h1; dataIn = 16'h00A1; reqIn = 1'b1; tick(2);
    check(ackOut == 1'b0, "R6 locked port refuses", ackOut, 0);
    reqIn = 1'b0; tick(2);
    send(4'h2, 16'h0000); send(4'h3, 16'h0000); send(4'h4, 16'h9999);
    check(writes == w0, "R6 no write while locked", writes, w0);

    // R8: short erase
    w0 = wipes;
    hold_erase(LIM);
    check(wipes == w0 && lockOut == 1'b1, "R8 short erase no effect", lockOut, 1);
    hold_erase(LIM - 3);
    check(wipes == w0, "R8 counter restarts", wipes, w0);

    // R7: long erase
    hold_erase(LIM + 6);
    check(wipes == w0 + 1, "R7 single wipe pulse", wipes, w0 + 1);
    check(lockOut == 1'b0, "R7 lock cleared", lockOut, 0);
    check(rd(32'h120010) == -1, "R7 memory wiped", rd(32'h120010), -1);
    send(4'h4, 16'h6666);
    check(errOut == 1'b0, "R7 sequencer idle after wipe", errOut, 0);
    send(4'h1, 16'h00A1); send(4'h2, 16'h0003); send(4'h3, 16'h0001);
    send(4'h4, 16'h5A5A);
    check(rd(32'h10003) == 16'h5A5A, "R7 writes resume", rd(32'h10003), 16'h5A5A);

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule